// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Scheduling

This block joins a simple host request port to an asynchronous DRAM whose address pins are shared between row and column. The host raises a request with a write flag, a full address (row in the upper bits, column in the lower bits) and write data. It holds them until the controller answers with a single-cycle acknowledge, which for a read carries the data. On the memory side the controller drives the row strobe, the column strobe, the write strobe (all active low), the shared address pins and the data toward the device.

After the row is opened, the controller leaves the row strobe low. Later requests to the same row then need only a column cycle each. The row is closed when a request names a different row, when refresh work is due, or when the row strobe is close to its longest allowed low time. A timer declares one refresh due every `T_REFI` clocks, and a counter records how many are owed. Refreshes wait while the host keeps the port busy. Once the backlog reaches `OWED_MAX`, host traffic is held off and refreshes run until the backlog is empty. A refresh lowers the column strobe first and then the row strobe, so the device uses its own internal row counter.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all three strobes are high and the acknowledge is low.
- R2: The row address (`host_addr[7:4]`) is placed on the address pins when the row strobe falls. The row strobe stays low for at least `T_RCD` cycles before the column strobe falls, with the column (`host_addr[3:0]`) on the pins. Each column pulse is at least `T_CAS` cycles low, and at least `T_CP` cycles high before the next column pulse in the same page.
- R3: A request to the row that is already open is served without the row strobe rising.
- R4: Before the row strobe falls, for any reason, it has been high for at least `T_RP` cycles.
- R5: The row strobe is never low for more than `T_RAS_MAX` consecutive cycles, even while same-row requests keep arriving.
- R6: For a write, the write strobe goes low and the data driver is enabled at least one cycle before the column strobe falls, and the written value is stored. For a read, the write strobe stays high.
- R7: Each request receives exactly one acknowledge, lasting one cycle. For a read, `host_rdata` holds the addressed word during that cycle.
- R8: A refresh lowers the column strobe while the row strobe is high, and the row strobe falls at least one cycle later.
- R9: One refresh becomes due every `T_REFI` cycles. Completed refreshes never trail the due count by more than `OWED_MAX`, and an idle controller brings the backlog back to zero.
- R10: Under uninterrupted host traffic, refreshes are postponed until the backlog reaches exactly `OWED_MAX`. The backlog is then forced down, so refreshes keep happening during the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request pending; held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with acknowledge |
| host_ack | output | 1 | One-cycle completion pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_dq_out | output | DATA_W | Data driven to the device |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
The hardest state to reach is the forced refresh drain. The backlog has to climb to its ceiling while the host never lets go of the request line, so the controller never sees an idle gap in which it would refresh on its own. The bench therefore streams hundreds of mixed-row requests with the request held high across each acknowledge. A behavioural device model counts the refresh strobes it observes and compares them with a due count derived from elapsed cycles. This shows that the backlog reaches the ceiling exactly once per drain and never passes it.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // row strobe high, precharged
    ST_RCD,    // row opened, row address on pins
    ST_CSU,    // column address and write strobe set up
    ST_CAS,    // column strobe low
    ST_CPRE,   // column strobe high inside the page
    ST_OPEN,   // page open, waiting for a decision
    ST_PRE,    // row precharge
    ST_RFC,    // refresh: column strobe leads
    ST_RFR     // refresh: both strobes low
  } dstate_e;

  // True in the final cycle of a state lasting dur cycles.
  function automatic logic at_last(input int unsigned cnt, input int unsigned dur);
    return (cnt + 1) >= dur;
  endfunction

  // Row-low cycles consumed if a page access starts now:
  // this decision cycle, setup, the column pulse, column precharge, one more decision cycle.
  function automatic int unsigned page_cost(input int unsigned cas_w, input int unsigned cp_w);
    return 3 + cas_w + cp_w;
  endfunction

  // Whether a page access may start with age prior low cycles.
  function automatic logic access_fits(input int unsigned age, input int unsigned cas_w,
                                       input int unsigned cp_w, input int unsigned ras_max);
    return (age + page_cost(cas_w, cp_w)) <= ras_max;
  endfunction

endpackage

// File: rtl/dramc_refresh_tracker.sv
module dramc_refresh_tracker #(
  parameter int T_REFI   = 60,
  parameter int OWED_MAX = 4,
  parameter int OW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refresh_done,
  output logic          due_pulse,
  output logic [OW-1:0] owed,
  output logic          owed_any,
  output logic          force_refresh
);
  localparam int TW = (T_REFI > 2) ? $clog2(T_REFI) : 1;

  logic [TW-1:0] tmr_q;
  logic          drain_q;

  assign due_pulse     = (tmr_q == TW'(T_REFI - 1));
  assign owed_any      = (owed != '0);
  assign force_refresh = drain_q || (owed >= OW'(OWED_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= due_pulse ? '0 : tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      unique case ({due_pulse, refresh_done})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  // Once the ceiling is hit, keep draining until nothing is owed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
    end else if (owed >= OW'(OWED_MAX)) begin
      drain_q <= 1'b1;
    end else if (owed == '0) begin
      drain_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dramc_ras_guard.sv
module dramc_ras_guard #(
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RAS_MAX = 40,
  parameter int AGE_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_low,
  output logic [AGE_W-1:0] age,
  output logic             may_extend
);
  import dramc_pkg::*;

  assign may_extend = access_fits(32'(age), T_CAS, T_CP, T_RAS_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (!ras_low) begin
      age <= '0;
    end else if (age != '1) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/dramc_strobe_decode.sv
module dramc_strobe_decode #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int MA_W  = 4
) (
  input  dramc_pkg::dstate_e state,
  input  logic               wr,
  input  logic [ROW_W-1:0]   row,
  input  logic [COL_W-1:0]   col,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [MA_W-1:0]    addr,
  output logic               dq_oe
);
  import dramc_pkg::*;

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    dq_oe = 1'b0;
    unique case (state)
      ST_RCD: begin
        ras_n = 1'b0;
        addr  = MA_W'(row);
      end
      ST_CSU: begin
        ras_n = 1'b0;
        addr  = MA_W'(col);
        we_n  = !wr;
        dq_oe = wr;
      end
      ST_CAS: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        addr  = MA_W'(col);
        we_n  = !wr;
        dq_oe = wr;
      end
      ST_CPRE, ST_OPEN: ras_n = 1'b0;
      ST_RFC:  cas_n = 1'b0;
      ST_RFR: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 2,
  parameter int T_RFR     = 4,
  parameter int T_RAS_MAX = 40,
  parameter int T_REFI    = 60,
  parameter int OWED_MAX  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_req,
  input  logic                   host_we,
  input  logic [ROW_W+COL_W-1:0] host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  output logic                   host_ack,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  import dramc_pkg::*;

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int OWED_W = $clog2(OWED_MAX + 2);
  localparam int AGE_W  = $clog2(T_RAS_MAX + 2);
  localparam int CNT_W  = $clog2(T_RCD + T_CAS + T_CP + T_RP + T_RFR + 2);

  dstate_e             state_q, state_d;
  logic [CNT_W-1:0]    cnt_q;
  logic [ROW_W-1:0]    row_q, open_row_q;
  logic [COL_W-1:0]    col_q;
  logic                wr_q;
  logic [DATA_W-1:0]   wdata_q;

  // Named internal events
  logic                page_hit, may_extend, owed_any, force_refresh;
  logic                due_pulse, refresh_done, cas_last, accept, open_new;
  logic [OWED_W-1:0]   owed;
  logic [AGE_W-1:0]    ras_age;

  assign page_hit     = (host_addr[ADDR_W-1:COL_W] == open_row_q);
  assign cas_last     = (state_q == ST_CAS) && at_last(32'(cnt_q), T_CAS);
  assign refresh_done = (state_q == ST_RFR) && at_last(32'(cnt_q), T_RFR);
  assign open_new     = (state_q == ST_IDLE) && (state_d == ST_RCD);
  assign accept       = open_new || ((state_q == ST_OPEN) && (state_d == ST_CSU));

  dramc_refresh_tracker #(.T_REFI(T_REFI), .OWED_MAX(OWED_MAX), .OW(OWED_W)) u_refresh (
    .clk(clk), .rst_n(rst_n), .refresh_done(refresh_done), .due_pulse(due_pulse),
    .owed(owed), .owed_any(owed_any), .force_refresh(force_refresh)
  );

  dramc_ras_guard #(.T_CAS(T_CAS), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX), .AGE_W(AGE_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_low(!dram_ras_n), .age(ras_age), .may_extend(may_extend)
  );

  dramc_strobe_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_decode (
    .state(state_q), .wr(wr_q), .row(row_q), .col(col_q),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .addr(dram_addr), .dq_oe(dram_dq_oe)
  );

  assign dram_dq_out = wdata_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (owed_any && (!host_req || force_refresh)) state_d = ST_RFC;
        else if (host_req)                            state_d = ST_RCD;
      ST_RCD:  if (at_last(32'(cnt_q), T_RCD)) state_d = ST_CSU;
      ST_CSU:  state_d = ST_CAS;
      ST_CAS:  if (cas_last) state_d = ST_CPRE;
      ST_CPRE: if (at_last(32'(cnt_q), T_CP)) state_d = ST_OPEN;
      ST_OPEN:
        if (force_refresh || (owed_any && !host_req) || !may_extend || (host_req && !page_hit))
          state_d = ST_PRE;
        else if (host_req)
          state_d = ST_CSU;
      ST_PRE:  if (at_last(32'(cnt_q), T_RP)) state_d = ST_IDLE;
      ST_RFC:  state_d = ST_RFR;
      ST_RFR:  if (refresh_done) state_d = ST_PRE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      open_row_q <= '0;
    end else if (accept) begin
      row_q   <= host_addr[ADDR_W-1:COL_W];
      col_q   <= host_addr[COL_W-1:0];
      wr_q    <= host_we;
      wdata_q <= host_wdata;
      if (open_new) open_row_q <= host_addr[ADDR_W-1:COL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= cas_last;
      if (cas_last && !wr_q) host_rdata <= dram_dq_in;
    end
  end
endmodule

// File: rtl/dramc_checker.sv
module dramc_checker #(
  parameter int T_RP      = 2,
  parameter int T_RAS_MAX = 40,
  parameter int OWED_MAX  = 4,
  parameter int OW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          ack,
  input logic [OW-1:0] owed,
  input logic          refresh_done
);
  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 16'(T_RP);
      lo_cnt <= '0;
    end else begin
      hi_cnt <= ras_n ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= ras_n ? '0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  AST_ROW_LEADS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $past(!ras_n));                       // R2
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(T_RP)));                           // R4
  AST_RAS_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (lo_cnt < 16'(T_RAS_MAX)));                             // R5
  AST_WE_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |-> $past(!we_n));               // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);                                                     // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));                       // R8
  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX));                                            // R9
  AST_DONE_HAS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done |-> (owed != '0));                                    // R9
endmodule

bind pagemode_dram_ctrl dramc_checker #(
  .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX), .OWED_MAX(OWED_MAX), .OW(OWED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .ack(host_ack), .owed(owed), .refresh_done(refresh_done)
);

// File: tb/test_pagemode_dram_ctrl.sv
module test_pagemode_dram_ctrl;
  localparam int ROW_W = 4, COL_W = 4, DW = 8;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2;
  localparam int T_RAS_MAX = 40, T_REFI = 60, OWED_MAX = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata, dram_addr, dram_dq_out;
  logic [7:0] dq_in = '0;
  logic host_ack, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [3:0] dram_addr4;

  int n_checks = 0, n_fail = 0;
  int elapsed = 0, refreshes = 0, ras_falls = 0, max_lo = 0, max_lag = 0, min_hi = 1000;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];

  always #10 clk = ~clk;

  pagemode_dram_ctrl i_pagemode_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr4), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in)
  );
  assign dram_addr = {4'h0, dram_addr4};

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst_n) elapsed = 0; else elapsed++;

  // Behavioural device model: samples once per cycle between edges.
  logic p_ras, p_cas, p_we, p_ack;
  int hi_len, lo_len, cas_lo, cas_hi, lag;
  logic [3:0] row_l;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1; p_ack = 0;
      hi_len = 1000; lo_len = 0; cas_lo = 0; cas_hi = 1000; row_l = '0;
      refreshes = 0; ras_falls = 0; max_lo = 0; max_lag = 0; min_hi = 1000;
    end else begin
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        if (hi_len < min_hi) min_hi = hi_len;
        if (hi_len < T_RP) check(0, "R4", "row precharge", hi_len, T_RP);
        if (!dram_cas_n) begin
          if (p_cas) check(0, "R8", "strobes fell together", 0, 1);
          else refreshes++;
        end else row_l = dram_addr[3:0];
      end
      if (p_cas && !dram_cas_n && !dram_ras_n) begin
        if (p_ras) check(0, "R2", "column before row", 0, 1);
        else if (lo_len < T_RCD) check(0, "R2", "row-to-column delay", lo_len, T_RCD);
        if (cas_hi < T_CP) check(0, "R2", "column precharge", cas_hi, T_CP);
        if (!dram_we_n) begin
          if (p_we) check(0, "R6", "write strobe setup", 0, 1);
          if (!dram_dq_oe) check(0, "R6", "data driver off", 0, 1);
          mem[{row_l, dram_addr[3:0]}] = dram_dq_out;
        end
      end
      if (!p_cas && dram_cas_n && !dram_ras_n && cas_lo < T_CAS)
        check(0, "R2", "column pulse width", cas_lo, T_CAS);
      if (host_ack && p_ack) check(0, "R7", "acknowledge longer than one cycle", 2, 1);
      if (dram_ras_n) begin hi_len++; lo_len = 0; end else begin lo_len++; hi_len = 0; end
      if (dram_cas_n) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
      if (lo_len > max_lo) max_lo = lo_len;
      if (lo_len > T_RAS_MAX) check(0, "R5", "row strobe low too long", lo_len, T_RAS_MAX);
      if (!dram_ras_n && !dram_cas_n && dram_we_n) dq_in = mem[{row_l, dram_addr[3:0]}];
      lag = elapsed / T_REFI - refreshes;
      if (lag > max_lag) max_lag = lag;
      if (lag > OWED_MAX) check(0, "R9", "refresh backlog", lag, OWED_MAX);
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_ack = host_ack;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; host_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Called at a negedge; returns at the negedge where the acknowledge is seen.
  task automatic host_op(input logic we, input logic [7:0] a, input logic [7:0] wd,
                         input bit keep, output logic [7:0] rd);
    int w;
    host_req = 1; host_we = we; host_addr = a; host_wdata = wd;
    w = 0;
    do begin @(negedge clk); w++; end while (!host_ack && w < 3000);
    if (!host_ack) check(0, "R7", "no acknowledge", 0, 1);
    rd = host_rdata;
    if (we) shadow[a] = wd;
    if (!keep) host_req = 0;
  endtask

  task automatic rd_check(input logic [7:0] a, input bit keep, input string req);
    logic [7:0] r;
    host_op(0, a, 8'h00, keep, r);
    check(r == shadow[a], req, "read data", r, shadow[a]);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check(dram_ras_n == 1, "R1", "row strobe in reset", dram_ras_n, 1);
    check(dram_cas_n == 1, "R1", "column strobe in reset", dram_cas_n, 1);
    check(dram_we_n == 1, "R1", "write strobe in reset", dram_we_n, 1);
    check(host_ack == 0, "R1", "ack in reset", host_ack, 0);
    rst_n = 1;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && !host_ack, "R1", "idle after reset", dram_ras_n, 1);
  endtask

  task automatic t_page_hit();
    logic [7:0] r;
    int f0;
    do_reset();
    f0 = ras_falls;
    host_op(1, 8'h31, 8'hA7, 1, r);
    host_op(1, 8'h32, 8'h5C, 1, r);
    rd_check(8'h31, 1, "R3");
    rd_check(8'h32, 0, "R7");
    check(ras_falls - f0 == 1, "R3", "row opens for same-row burst", ras_falls - f0, 1);
    check(mem[8'h31] == 8'hA7, "R6", "stored write", mem[8'h31], 8'hA7);
  endtask

  task automatic t_row_miss();
    logic [7:0] r;
    int f0;
    do_reset();
    f0 = ras_falls;
    host_op(1, 8'h10, 8'h11, 0, r);
    @(negedge clk);
    host_op(1, 8'h20, 8'h22, 0, r);
    @(negedge clk);
    rd_check(8'h10, 0, "R4");
    @(negedge clk);
    rd_check(8'h20, 0, "R4");
    check(ras_falls - f0 == 4, "R4", "row reopened per miss", ras_falls - f0, 4);
    check(min_hi >= T_RP, "R4", "shortest precharge", min_hi, T_RP);
  endtask

  task automatic t_ras_limit();
    logic [7:0] r;
    int f0;
    do_reset();
    f0 = ras_falls;
    for (int i = 0; i < 16; i++) host_op(1, {4'h5, 4'(i)}, 8'(i * 9 + 1), 1, r);
    for (int i = 0; i < 16; i++) rd_check({4'h5, 4'(i)}, i != 15, "R5");
    check(max_lo <= T_RAS_MAX, "R5", "longest row-low run", max_lo, T_RAS_MAX);
    check(ras_falls - f0 >= 3, "R5", "page closed at limit", ras_falls - f0, 3);
  endtask

  task automatic t_refresh_idle();
    do_reset();
    repeat (200) @(negedge clk);
    check(refreshes == 3, "R8", "refreshes while idle", refreshes, 3);
    check(elapsed / T_REFI - refreshes == 0, "R9", "idle backlog", elapsed / T_REFI - refreshes, 0);
  endtask

  task automatic t_pattern();
    logic [7:0] r;
    do_reset();
    for (int i = 0; i < 24; i++) host_op(1, 8'(i * 37 + 5), 8'(i * 13 + 7), i != 23, r);
    @(negedge clk);
    for (int i = 23; i >= 0; i--) rd_check(8'(i * 37 + 5), i != 0, "R6");
  endtask

  task automatic t_load();
    logic [7:0] r, a, prev;
    int r0, w;
    do_reset();
    prev = 8'h00;
    for (int i = 0; i < 300; i++) begin
      if (i % 4 == 3) rd_check(prev, i != 299, "R10");
      else begin
        a = 8'(i * 29 + 7);
        host_op(1, a, 8'(i * 7 + 3), i != 299, r);
        prev = a;
      end
      if (i == 150) r0 = refreshes;
    end
    check(max_lag == OWED_MAX, "R10", "backlog ceiling reached", max_lag, OWED_MAX);
    check(refreshes > r0, "R10", "refreshes during load", refreshes - r0, 1);
    w = 0;
    while ((elapsed / T_REFI - refreshes) != 0 && w < 3 * T_REFI) begin @(negedge clk); w++; end
    check(elapsed / T_REFI - refreshes == 0, "R9", "backlog drained", elapsed / T_REFI - refreshes, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    t_reset();
    t_page_hit();
    t_row_miss();
    t_ras_limit();
    t_refresh_idle();
    t_pattern();
    t_load();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule